// File: doc/BRIEF.md
# Packed 36-bit Word Unpacker

The block turns a stream of 32-bit transport words into the 36-bit capture words they carry. Words arrive in slices of nine. The first eight words of a slice supply the low 32 bits of eight capture words. The ninth word collects the top four bits of all eight. Those nibbles are stored in reverse order: the first capture word's nibble sits in the highest nibble of the ninth word.

A transfer begins with a `start` pulse and a count of wanted 36-bit words. The block then accepts ceil(count/8) whole slices on its input. It holds each slice until the ninth word has arrived, then emits the capture words of that slice in order. After exactly `count` outputs it drops the tail of the final slice. The transport side is expected to mark its final word with `in_last`, and any disagreement with the expected length raises a sticky error.

Both streams are valid/ready. A word moves on any rising edge where valid and ready are both high. `in_ready` is high only while a slice is being collected. `out_valid` is high only while a collected slice is being emitted. Output back-pressure therefore holds the input off, and no word is lost or repeated. Once raised, `out_valid` and `out_data` stay fixed until the output handshake.

Top module: `word36_unpacker`

## Requirements
- R1: After reset, `busy`, `in_ready`, `out_valid` and `len_err` are all 0.
- R2: A `start` pulse in idle with a nonzero `word_count` makes `busy` and `in_ready` 1 from the next cycle. A `start` with `word_count` 0 leaves the block idle. A `start` while busy is ignored, and the running transfer keeps its original count.
- R3: `out_valid` stays 0 until the ninth word of the current slice has been accepted. `in_ready` and `out_valid` are never both 1.
- R4: Bits 31:0 of output k of a slice (k = 0..7) equal input word k of that slice.
- R5: Bits 35:32 of output k of a slice equal bits (31-4k) down to (28-4k) of input word 8 of that slice.
- R6: A transfer of count N accepts exactly 9*ceil(N/8) input words and emits exactly N outputs, in input order. Outputs beyond N in the final slice are discarded.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged on the next cycle.
- R8: If `in_last` is 1 on a word other than the final expected one, `len_err` becomes 1. The transfer then ends at once, and that slice emits nothing.
- R9: If the final expected word arrives with `in_last` 0, `len_err` becomes 1, but the final slice is still emitted normally. `len_err` holds until the next accepted start clears it.
- R10: `busy` returns to 0 in the cycle after the last output handshake of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled when idle) |
| word_count | input | COUNT_W | Number of 36-bit words wanted |
| busy | output | 1 | A transfer is in progress |
| len_err | output | 1 | Sticky input length mismatch flag |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block accepts an input word |
| in_data | input | 32 | Transport word |
| in_last | input | 1 | Marks the final transport word |
| out_valid | output | 1 | Output capture word present |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 36 | Unpacked capture word |

## Verification
The bench aims at counts that end inside a slice (1, 7, 9 and random values) and at the exact 8 and 16 boundaries. A design that emitted the discarded tail, or that stopped consuming before the slice was whole, would show a wrong output or input tally. Random stalls on both streams expose outputs that change under back-pressure and words dropped or repeated across a stall. Every nibble position of the ninth word is compared, so a design that reversed the nibble order, or presented data before the ninth word, would miscompare. Early and missing end markers, plus a start pulse in mid-transfer, check the error flag, the abort and the ignoring of a second start.

// File: rtl/unpk_pkg.sv
package unpk_pkg;
  localparam int unsigned LANES  = 8;
  localparam int unsigned LOW_W  = 32;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned WORD_W = LOW_W + NIB_W;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned FIDX_W = LANE_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_DRAIN = 2'd2
  } unpk_state_e;

  function automatic logic [NIB_W-1:0] pick_nibble(
    input logic [LOW_W-1:0]  hi_word,
    input logic [LANE_W-1:0] lane
  );
    logic [4:0] shamt;
    shamt = 5'd28 - {lane, 2'b00};
    return NIB_W'(hi_word >> shamt);
  endfunction
endpackage

// File: rtl/unpk_seq.sv
module unpk_seq
  import unpk_pkg::*;
#(
  parameter int unsigned COUNT_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [COUNT_W-1:0]  word_count,
  input  logic                in_valid,
  input  logic                in_last,
  input  logic                out_ready,
  output logic                in_ready,
  output logic                out_valid,
  output logic                busy,
  output logic                len_err,
  output logic                lo_we,
  output logic                hi_we,
  output logic [LANE_W-1:0]   fill_lane,
  output logic [LANE_W-1:0]   emit_lane
);
  localparam int unsigned SLC_W = COUNT_W - 2;

  unpk_state_e          state_q;
  logic [FIDX_W-1:0]    fill_q;
  logic [LANE_W-1:0]    emit_q;
  logic [COUNT_W-1:0]   rem_q;
  logic [SLC_W-1:0]     slc_q;
  logic                 err_q;

  logic [COUNT_W:0]     cnt_round;
  logic                 in_acc;
  logic                 out_acc;
  logic                 last_exp;
  logic                 at_hi;

  assign cnt_round = {1'b0, word_count} + (COUNT_W+1)'(7);
  assign in_ready  = (state_q == ST_FILL);
  assign out_valid = (state_q == ST_DRAIN);
  assign busy      = (state_q != ST_IDLE);
  assign len_err   = err_q;
  assign in_acc    = in_valid && in_ready;
  assign out_acc   = out_valid && out_ready;
  assign at_hi     = (fill_q == FIDX_W'(LANES));
  assign last_exp  = (slc_q == SLC_W'(1)) && at_hi;
  assign lo_we     = in_acc && !at_hi;
  assign hi_we     = in_acc && at_hi;
  assign fill_lane = fill_q[LANE_W-1:0];
  assign emit_lane = emit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fill_q  <= '0;
      emit_q  <= '0;
      rem_q   <= '0;
      slc_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start && (word_count != '0)) begin
            state_q <= ST_FILL;
            rem_q   <= word_count;
            slc_q   <= cnt_round[COUNT_W:3];
            fill_q  <= '0;
            emit_q  <= '0;
            err_q   <= 1'b0;
          end
        end
        ST_FILL: begin
          if (in_acc) begin
            if (in_last && !last_exp) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
              fill_q  <= '0;
            end else begin
              if (!in_last && last_exp) err_q <= 1'b1;
              if (at_hi) begin
                state_q <= ST_DRAIN;
                fill_q  <= '0;
                emit_q  <= '0;
              end else begin
                fill_q <= fill_q + FIDX_W'(1);
              end
            end
          end
        end
        ST_DRAIN: begin
          if (out_acc) begin
            rem_q  <= rem_q - COUNT_W'(1);
            emit_q <= emit_q + LANE_W'(1);
            if (rem_q == COUNT_W'(1)) begin
              state_q <= ST_IDLE;
            end else if (emit_q == LANE_W'(LANES-1)) begin
              state_q <= ST_FILL;
              slc_q   <= slc_q - SLC_W'(1);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r3_drain_after_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(hi_we));

  a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (word_count != '0)) |=> (busy && in_ready && !len_err));

  a_r2_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (word_count == '0)) |=> !busy);

  a_r8_early_last_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_acc && in_last && !last_exp) |=> (!busy && len_err));

  a_r10_done_after_final: assert property (@(posedge clk) disable iff (!rst_n)
    (out_acc && (rem_q == COUNT_W'(1))) |=> !busy);
endmodule

// File: rtl/unpk_slice_buf.sv
module unpk_slice_buf
  import unpk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LOW_W-1:0]  in_data,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [LANE_W-1:0] fill_lane,
  input  logic [LANE_W-1:0] emit_lane,
  output logic [WORD_W-1:0] out_data
);
  logic [LOW_W-1:0] lo_q [LANES];
  logic [LOW_W-1:0] hi_q;
  logic [LANES-1:0] lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_we[g] = lo_we && (fill_lane == LANE_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) lo_q[g] <= '0;
      else if (lane_we[g]) lo_q[g] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hi_q <= '0;
    else if (hi_we) hi_q <= in_data;
  end

  assign out_data = {pick_nibble(hi_q, emit_lane), lo_q[emit_lane]};

  a_r4_one_lane_written: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we) && !(lo_we && hi_we));
endmodule

// File: rtl/word36_unpacker.sv
module word36_unpacker
  import unpk_pkg::*;
#(
  parameter int unsigned COUNT_W = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [COUNT_W-1:0] word_count,
  output logic               busy,
  output logic               len_err,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_data,
  input  logic               in_last,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [35:0]        out_data
);
  logic              lo_we;
  logic              hi_we;
  logic [LANE_W-1:0] fill_lane;
  logic [LANE_W-1:0] emit_lane;

  unpk_seq #(.COUNT_W(COUNT_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .word_count(word_count),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .busy      (busy),
    .len_err   (len_err),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .fill_lane (fill_lane),
    .emit_lane (emit_lane)
  );

  unpk_slice_buf i_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_data  (in_data),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .fill_lane(fill_lane),
    .emit_lane(emit_lane),
    .out_data (out_data)
  );

  a_r7_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: tb/test_word36_unpacker.sv
module test_word36_unpacker;
  localparam int CW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic          busy, len_err, in_ready, out_valid;
  logic          in_valid = 1'b0;
  logic [31:0]   in_data = '0;
  logic          in_last = 1'b0;
  logic          out_ready = 1'b0;
  logic [35:0]   out_data;

  int checks = 0;
  int fails = 0;
  logic [31:0] words [0:63];

  always #5 clk = ~clk;

  word36_unpacker #(.COUNT_W(CW)) i_word36_unpacker (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count),
    .busy(busy), .len_err(len_err), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [35:0] expect_word(input int j);
    int s = j / 8;
    int k = j % 8;
    logic [31:0] hw = words[s*9 + 8];
    return {hw[31-4*k -: 4], words[s*9 + k]};
  endfunction

  // count: wanted words; last_pos: index carrying in_last (-1: none);
  // pv/pr: valid/ready percentages; poke: pulse a stray start mid-transfer
  task automatic run_xfer(input int count, input int last_pos, input int pv,
                          input int pr, input bit poke);
    int n9 = ((count + 7) / 8) * 9;
    int n_offer;
    int exp_out;
    int idx = 0;
    int ocnt = 0;
    int cyc = 0;
    bit prev_stall = 0;
    logic [35:0] prev_data = '0;
    bit early = (last_pos >= 0) && (last_pos < n9 - 1);
    n_offer = early ? last_pos + 1 : n9;
    exp_out = early ? ((last_pos / 9) * 8 < count ? (last_pos / 9) * 8 : count) : count;
    for (int i = 0; i < n9; i++) words[i] = $urandom;
    @(posedge clk); #1;
    start = 1'b1; word_count = CW'(count);
    @(posedge clk); #1;
    start = 1'b0; word_count = CW'(3);
    @(negedge clk);
    check(busy && in_ready, "R2 start", {62'd0, busy, in_ready}, 64'd3);
    while (1) begin
      bit acc_in;
      @(negedge clk);
      if (!busy) break;
      cyc++;
      acc_in = in_valid && in_ready;
      if (out_valid) begin
        check(!in_ready, "R3 no overlap", 64'(in_ready), 64'd0);
        check(idx >= 9 * (ocnt / 8 + 1), "R3 ninth word first", 64'(idx),
              64'(9 * (ocnt / 8 + 1)));
      end
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R7 hold", 64'(out_data),
              64'(prev_data));
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        check(out_data == expect_word(ocnt), "R4/R5 data", 64'(out_data),
              64'(expect_word(ocnt)));
        ocnt++;
      end
      if (cyc > 4000) break;
      @(posedge clk); #1;
      if (acc_in) idx++;
      start = poke && (cyc == 3);
      in_valid = (idx < n_offer) && ($urandom_range(0, 99) < pv);
      in_data  = (idx < n_offer) ? words[idx] : 32'h0;
      in_last  = (idx < n_offer) && (idx == last_pos);
      out_ready = ($urandom_range(0, 99) < pr);
    end
    #1;
    in_valid = 1'b0; in_last = 1'b0; start = 1'b0;
    check(ocnt == exp_out, "R6 output count", 64'(ocnt), 64'(exp_out));
    check(idx == n_offer, "R6 input count", 64'(idx), 64'(n_offer));
    check(len_err == (last_pos != n9 - 1), "R8/R9 len_err", 64'(len_err),
          64'(last_pos != n9 - 1));
    check(!busy, "R10 idle at end", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !in_ready && !out_valid && !len_err, "R1 reset",
          {60'd0, busy, in_ready, out_valid, len_err}, 64'd0);
    // R2: zero count stays idle
    @(posedge clk); #1; start = 1'b1; word_count = '0;
    @(posedge clk); #1; start = 1'b0;
    @(negedge clk);
    check(!busy && !in_ready, "R2 zero count", 64'(busy), 64'd0);
    // directed boundaries (R6 tail drop, full slices)
    run_xfer(8, 8, 100, 100, 0);
    run_xfer(1, 8, 100, 100, 0);
    run_xfer(7, 8, 70, 50, 0);
    run_xfer(9, 17, 100, 30, 0);
    run_xfer(16, 17, 60, 100, 0);
    // R2: stray start while busy is ignored
    run_xfer(24, 26, 80, 60, 1);
    // R8: early end marker aborts
    run_xfer(16, 12, 100, 100, 0);
    run_xfer(16, 8, 90, 90, 0);
    // R9: missing end marker still drains
    run_xfer(8, -1, 100, 100, 0);
    // R9: next start clears the flag
    run_xfer(5, 8, 100, 100, 0);
    // random transfers
    for (int t = 0; t < 30; t++) begin
      int c = $urandom_range(1, 48);
      run_xfer(c, ((c + 7) / 8) * 9 - 1, $urandom_range(30, 100),
               $urandom_range(30, 100), 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule